// File: doc/BRIEF.md
# Fixed-Frequency PWM Waveform Generator

This block produces a pulse-width-modulated level from a slow time base. A separate oscillator delivers single-cycle `tick` strobes on the system clock; the generator counts those strobes across a programmable cycle of `period + 1` ticks and holds its output high for the first `on` ticks of every cycle. The high fraction of a cycle is therefore `on / (period + 1)`. The output level then feeds a separate output-stage block.

Software-visible period and on values arrive on plain input buses. The generator keeps an active copy of both, and refreshes that copy only when a cycle completes, so a cycle never mixes old and new settings. No special mode is needed for full duty: programming `on` above `period` (for example on = 0xFF with period = 0xFE) keeps the output high. An `on` of zero keeps it low. A force-high input overrides the counter entirely. A period of zero is not a useful setting. It is still defined: it gives a one-tick cycle.

Top module: `pwm_cycle_gen`

## Requirements
- R1: While reset is asserted and after it is released, `pwm_out` is 0 until `run` or `force_hi` is raised.
- R2: While `run` is 0, the count stays at 0 and the active settings follow the inputs on every clock. `pwm_out` is 0 unless `force_hi` is 1.
- R3: While `run` is 1, the count advances by one only on clocks where `tick` is 1. It runs from 0 to the active period and wraps to 0, so one cycle spans period+1 ticks.
- R4: The output is high while the count is below the active on value. With period = 9 and on = 3, exactly 3 of every 10 ticks are high.
- R5: An active on value of 0 gives a constantly low output (without force).
- R6: With on = 0xFF and period = 0xFE, the output stays high for every clock of a running cycle.
- R7: Changes to `period_in` or `on_in` while running take effect only at the wrap point, that is, on the tick where the count equals the active period.
- R8: When `force_hi` is 1, `pwm_out` is 1 on the next clock, whatever the count and settings.
- R9: `pwm_out` is a register. Its value after a clock edge is `force_hi | (run & count < active_on)`, evaluated on the values just before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| arst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick | input | 1 | One-clock strobe from the variable-frequency time base |
| run | input | 1 | Enables counting; low holds the cycle at its start |
| period_in | input | CW (8) | Cycle length minus one, in ticks |
| on_in | input | CW (8) | Number of high ticks per cycle |
| force_hi | input | 1 | Drives the output high regardless of the counter |
| pwm_out | output | 1 | Registered PWM level |

## Verification
The bench builds the generator with its default 8-bit count width. That makes the full-duty corner reachable: on = 0xFF with period = 0xFE, and the count reaching 0xFE. Random tick gaps, setting changes in the middle of a cycle, and force pulses are run against a cycle-accurate model in the bench. This shows that new settings only apply at a wrap. Directed runs measure the high count per cycle, the zero-on case and the force override.

// File: rtl/pwm_gen_pkg.sv
package pwm_gen_pkg;

  // Action taken by the period counter on a given clock.
  typedef enum logic [1:0] {
    CNT_IDLE = 2'd0,  // run low: hold at zero, reload settings
    CNT_HOLD = 2'd1,  // running, no tick this clock
    CNT_STEP = 2'd2,  // running, tick, count below period
    CNT_WRAP = 2'd3   // running, tick, count at period: wrap and reload
  } cnt_act_e;

endpackage

// File: rtl/pwm_rst_sync.sv
module pwm_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        assign sync_d[i] = 1'b1;
      end else begin : g_rest
        assign sync_d[i] = sync_q[i-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign rst_n_sync = sync_q[STAGES-1];

endmodule

// File: rtl/pwm_cfg_shadow.sv
module pwm_cfg_shadow #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_en,
  input  logic [CW-1:0] period_in,
  input  logic [CW-1:0] on_in,
  output logic [CW-1:0] period_act,
  output logic [CW-1:0] on_act
);

  logic [CW-1:0] period_q, period_d;
  logic [CW-1:0] on_q, on_d;

  // Next-state: copy the requested settings only when the counter says so.
  always_comb begin
    period_d = period_q;
    on_d     = on_q;
    if (load_en) begin
      period_d = period_in;
      on_d     = on_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      period_q <= '0;
      on_q     <= '0;
    end else begin
      period_q <= period_d;
      on_q     <= on_d;
    end
  end

  assign period_act = period_q;
  assign on_act     = on_q;

  // R7
  hold_between_loads_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load_en |=> ($stable(period_act) && $stable(on_act)));

  // R7
  load_captures_inputs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |=> (period_act == $past(period_in) && on_act == $past(on_in)));

endmodule

// File: rtl/pwm_period_counter.sv
module pwm_period_counter
  import pwm_gen_pkg::*;
#(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          tick,
  input  logic [CW-1:0] period_act,
  output logic [CW-1:0] cnt,
  output logic          load_en
);

  localparam logic [CW-1:0] ONE = CW'(1);

  cnt_act_e      act;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          at_end;

  assign at_end = (cnt_q == period_act);

  // Decide what this clock does.
  always_comb begin
    if (!run)        act = CNT_IDLE;
    else if (!tick)  act = CNT_HOLD;
    else if (at_end) act = CNT_WRAP;
    else             act = CNT_STEP;
  end

  // Next-state for the count.
  always_comb begin
    unique case (act)
      CNT_IDLE: cnt_d = '0;
      CNT_HOLD: cnt_d = cnt_q;
      CNT_STEP: cnt_d = cnt_q + ONE;
      CNT_WRAP: cnt_d = '0;
      default:  cnt_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt     = cnt_q;
  assign load_en = (act == CNT_IDLE) || (act == CNT_WRAP);

  // R3
  cnt_within_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= period_act);

  // R3
  cnt_hold_no_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !tick) |=> $stable(cnt));

  // R3
  cnt_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && tick && cnt == period_act) |=> (cnt == '0));

  // R2
  cnt_idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (cnt == '0));

endmodule

// File: rtl/pwm_level_out.sv
module pwm_level_out #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          force_hi,
  input  logic [CW-1:0] cnt,
  input  logic [CW-1:0] on_act,
  output logic          pwm_out
);

  logic below_on;
  logic lvl_q, lvl_d;

  // Strict compare: on = 0 never high, on > period always high.
  assign below_on = (cnt < on_act);

  always_comb begin
    lvl_d = force_hi | (run & below_on);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_q <= 1'b0;
    else        lvl_q <= lvl_d;
  end

  assign pwm_out = lvl_q;

  // R8
  force_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    force_hi |=> pwm_out);

  // R5
  zero_on_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!force_hi && on_act == '0) |=> !pwm_out);

  // R2
  idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!force_hi && !run) |=> !pwm_out);

endmodule

// File: rtl/pwm_cycle_gen.sv
module pwm_cycle_gen #(
  parameter int CW       = 8,
  parameter int SYNC_STG = 2
) (
  input  logic          clk,
  input  logic          arst_n,
  input  logic          tick,
  input  logic          run,
  input  logic [CW-1:0] period_in,
  input  logic [CW-1:0] on_in,
  input  logic          force_hi,
  output logic          pwm_out
);

  logic          rst_n;
  logic          load_en;
  logic [CW-1:0] period_act;
  logic [CW-1:0] on_act;
  logic [CW-1:0] cnt;

  pwm_rst_sync #(.STAGES(SYNC_STG)) u_rst (
    .clk        (clk),
    .arst_n     (arst_n),
    .rst_n_sync (rst_n)
  );

  pwm_cfg_shadow #(.CW(CW)) u_shadow (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_en    (load_en),
    .period_in  (period_in),
    .on_in      (on_in),
    .period_act (period_act),
    .on_act     (on_act)
  );

  pwm_period_counter #(.CW(CW)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .run        (run),
    .tick       (tick),
    .period_act (period_act),
    .cnt        (cnt),
    .load_en    (load_en)
  );

  pwm_level_out #(.CW(CW)) u_lvl (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (run),
    .force_hi (force_hi),
    .cnt      (cnt),
    .on_act   (on_act),
    .pwm_out  (pwm_out)
  );

  // R1
  reset_low_chk: assert property (@(posedge clk)
    !rst_n |=> !pwm_out);

endmodule

// File: tb/pwm_cycle_gen_bench.sv
module pwm_cycle_gen_bench;

  localparam int CW = 8;

  logic          clk = 1'b0;
  logic          arst_n;
  logic          tick, run, force_hi;
  logic [CW-1:0] period_in, on_in;
  logic          pwm_out;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 0;

  // Bench model state
  int m_cnt, m_per, m_on;

  always #10 clk = ~clk;  // 50 MHz

  pwm_cycle_gen #(.CW(CW)) u_pwm_cycle_gen (
    .clk(clk), .arst_n(arst_n), .tick(tick), .run(run),
    .period_in(period_in), .on_in(on_in), .force_hi(force_hi),
    .pwm_out(pwm_out)
  );

  function automatic logic exp_level(logic f, logic r, int c, int o);
    return f | (r & (c < o));
  endfunction

  task automatic check(string tag, logic act, logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: pwm_out=%0b expected %0b", tag, act, exp);
    end
  endtask

  // Advance one clock with the inputs as currently driven; compare output.
  task automatic step(string tag);
    logic e;
    e = exp_level(force_hi, run, m_cnt, m_on);
    if (!run) begin
      m_cnt = 0; m_per = period_in; m_on = on_in;
    end else if (tick) begin
      if (m_cnt == m_per) begin
        m_cnt = 0; m_per = period_in; m_on = on_in;
      end else m_cnt++;
    end
    @(posedge clk); #1;
    check(tag, pwm_out, e);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(20 * 150000);
    n_run++; n_fail++;
    $display("FAIL watchdog: hung run, expected completion");
    finish_run();
  end

  initial begin
    int highs;
    void'($urandom(32'd20240611));
    arst_n = 0; tick = 0; run = 0; force_hi = 0;
    period_in = 8'd9; on_in = 8'd3;
    m_cnt = 0; m_per = 0; m_on = 0;
    repeat (3) @(posedge clk);
    #1 check("R1 in reset", pwm_out, 1'b0);
    arst_n = 1;
    repeat (5) begin @(posedge clk); #1; check("R1 after release", pwm_out, 1'b0); end
    m_per = period_in; m_on = on_in;

    // R2: idle with ticks keeps output low
    tick = 1;
    repeat (10) step("R2 idle");

    // R4: period 9, on 3, tick every clock -> 15 highs in 50 ticks
    run = 1; highs = 0;
    for (int i = 0; i < 50; i++) begin step("R4 trace"); highs += int'(pwm_out); end
    n_run++;
    if (highs != 15) begin n_fail++; $display("FAIL R4: highs=%0d expected 15", highs); end

    // R5: on = 0 stays low
    run = 0; on_in = 8'd0; step("R5 load");
    run = 1;
    for (int i = 0; i < 40; i++) step("R5 zero on");

    // R6: full duty
    run = 0; period_in = 8'hFE; on_in = 8'hFF; step("R6 load");
    run = 1;
    for (int i = 0; i < 600; i++) begin
      step("R6 model");
      check("R6 full duty", pwm_out, 1'b1);
    end

    // R7: mid-cycle change applies only at wrap
    run = 0; period_in = 8'd9; on_in = 8'd2; step("R7 load");
    run = 1;
    repeat (4) step("R7 pre");
    on_in = 8'd8; period_in = 8'd4;
    highs = 0;
    for (int i = 0; i < 6; i++) begin step("R7 old cycle"); highs += int'(pwm_out); end
    n_run++;
    if (highs != 0) begin n_fail++; $display("FAIL R7: highs=%0d expected 0", highs); end
    for (int i = 0; i < 10; i++) step("R7 new cycle");

    // R8: force overrides zero-on and idle
    on_in = 8'd0; force_hi = 1;
    for (int i = 0; i < 20; i++) begin
      step("R8 model");
      check("R8 forced", pwm_out, 1'b1);
    end
    run = 0;
    repeat (5) step("R8 idle forced");
    force_hi = 0;

    // R3/R9: random ticks, settings, force, run
    run = 1; period_in = 8'd5; on_in = 8'd2;
    for (int i = 0; i < 20000; i++) begin
      tick = ($urandom % 3) == 0;
      if (($urandom % 50) == 0) period_in = CW'($urandom % 12);
      if (($urandom % 50) == 0) on_in     = CW'($urandom % 14);
      if (($urandom % 200) == 0) period_in = 8'hFE;
      force_hi = ($urandom % 97) == 0;
      run      = ($urandom % 400) != 0;
      step((i % 2) ? "R3 random" : "R9 random");
    end

    finish_run();
  end

endmodule